// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller Core

This block gathers a vector of external interrupt lines, keeps per-interrupt enable, pending, active and priority state in 32-bit word registers, and offers the core the most urgent interrupt that is enabled and pending. A priority-grouping split decides which part of each priority value counts for preemption. Only the group part decides whether a new interrupt may interrupt the one now running. The sub-priority part only orders interrupts that are waiting.

The core sees a request flag and the chosen interrupt number. It pulses an accept strobe to take that interrupt, and a return strobe when the handler finishes. A nesting stack records the order of activation, so each return retires the most recently accepted interrupt. The preemption threshold then falls back to the interrupts still active. Software reaches the state through a single-cycle register port. Writes take effect at the next clock edge and reads are combinational. Enable and pending state each have a set register and a clear register. A trigger register raises any interrupt by number.

Top module: `nvic_core`

## Requirements
- R1: After reset every writable register reads 0x00000000, no interrupt is active and `core_req` is low.
- R2: The read-only type register at word 0x00 returns the number of 32-interrupt groups minus one in bits [3:0], with all other bits zero. Writes to it have no effect.
- R3: Writing ones to word 0x08+g enables interrupts 32g..32g+31. Writing ones to word 0x10+g disables them. Zero bits change nothing. Both words read back the current enable bits of group g.
- R4: A rising edge on `irq_lines[i]` sets pending bit i at that clock edge, even when interrupt i is disabled. A disabled interrupt is never requested.
- R5: Writing ones to word 0x18+g sets pending bits and writing ones to word 0x20+g clears them. Both words read back the pending bits of group g.
- R6: Writing an interrupt number to bits [7:0] of word 0x02 sets that pending bit, exactly as the set-pending write does. A number at or above NUM_IRQ is ignored.
- R7: Priority word 0x40+k holds interrupt 4k+b in byte lane b. The priority sits in the top PRIO_BITS bits of each byte and the lower bits read zero. A lower value is more urgent.
- R8: `core_req` is high when an interrupt is enabled, pending, not active and allowed to preempt. `core_num` then names the one with the lowest priority byte, and the lower number wins a tie.
- R9: An accept while `core_req` is high clears that interrupt's pending bit and sets its active bit at the same edge. Active bits read at word 0x28+g and are read-only.
- R10: Word 0x01 bits [2:0] hold the split S. The group part of a priority byte is bits [7:S+1]. An interrupt is requested while others are active only if its group part is strictly below the group part of every active interrupt.
- R11: A return strobe clears the active bit of the most recently accepted interrupt that is still active, and preemption is then judged against the remaining active interrupts.
- R12: Bits of interrupts at or above NUM_IRQ, and words of groups or priority slots that are not implemented, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_IRQ | External interrupt lines, rising edge sets pending |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| core_req | output | 1 | An interrupt is offered to the core |
| core_num | output | 8 | Number of the offered interrupt |
| core_accept | input | 1 | Core takes the offered interrupt |
| core_return | input | 1 | Core finishes the current handler |

## Verification
A wrong pending, enable or priority bit shows at `core_req`/`core_num` in the cycle right after the edge that stored it, because the request is combinational from stored state. A corrupted nesting stack stays hidden until a return strobe. It then shows as the wrong active bit cleared, or as a request that should stay blocked by a lower group still active. The directed tests therefore follow each accept and return with readback of the active words and a check of the request. Group-split changes are tested on a live nest, so a wrong group mask changes the preemption result at once.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
   // word addresses of the register windows
   localparam logic [6:0] A_TYPE  = 7'h00;
   localparam logic [6:0] A_SPLIT = 7'h01;
   localparam logic [6:0] A_TRIG  = 7'h02;
   localparam logic [6:0] A_SETEN = 7'h08;
   localparam logic [6:0] A_CLREN = 7'h10;
   localparam logic [6:0] A_SETPD = 7'h18;
   localparam logic [6:0] A_CLRPD = 7'h20;
   localparam logic [6:0] A_ACT   = 7'h28;
   localparam logic [6:0] A_PRIO  = 7'h40;

   // bits of a priority byte that form the preempting group part
   function automatic logic [7:0] group_keep(input logic [2:0] split);
      logic [8:0] m;
      m = (9'd2 << split) - 9'd1;
      return ~m[7:0];
   endfunction
endpackage

// File: rtl/nvic_arbiter.sv
module nvic_arbiter #(
   parameter int NUM_IRQ = 40
) (
   input  logic [NUM_IRQ-1:0]   cand,
   input  logic [NUM_IRQ-1:0]   active,
   input  logic [NUM_IRQ*8-1:0] prio_bytes,
   input  logic [2:0]           split,
   output logic                 req,
   output logic [7:0]           req_num
);
   import nvic_pkg::*;

   logic       found, any_act;
   logic [7:0] best_b, thr, keep, g_i;

   always_comb begin
      keep    = group_keep(split);
      found   = 1'b0;
      best_b  = 8'hFF;
      req_num = 8'd0;
      any_act = 1'b0;
      thr     = 8'hFF;
      g_i     = 8'd0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         // strict compare keeps the lower number on a tie
         if (cand[i] && (!found || prio_bytes[i*8 +: 8] < best_b)) begin
            found   = 1'b1;
            best_b  = prio_bytes[i*8 +: 8];
            req_num = 8'(i);
         end
         g_i = prio_bytes[i*8 +: 8] & keep;
         if (active[i] && (!any_act || g_i < thr)) begin
            any_act = 1'b1;
            thr     = g_i;
         end
      end
      req = found && (!any_act || ((best_b & keep) < thr));
   end
endmodule

// File: rtl/nvic_nest_stack.sv
module nvic_nest_stack #(
   parameter int DEPTH = 8,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] push_data,
   output logic [W-1:0] top,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [2**PW];
   logic [PW:0]   cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == (PW+1)'(DEPTH));
   assign top   = empty ? '0 : mem[PW'(cnt_q - 1'b1)];

   always_ff @(posedge clk) begin
      if (push) mem[PW'((pop && !empty) ? cnt_q - 1'b1 : cnt_q)] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else cnt_q <= cnt_q + (PW+1)'(push && !(pop && !empty)) - (PW+1)'(pop && !empty && !push);
   end

   // R11
   stk_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> !full);
endmodule

// File: rtl/nvic_core.sv
module nvic_core #(
   parameter int NUM_IRQ   = 40,
   parameter int PRIO_BITS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic               bus_we,
   input  logic [6:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               core_req,
   output logic [7:0]         core_num,
   input  logic               core_accept,
   input  logic               core_return
);
   import nvic_pkg::*;

   localparam int NGRP  = (NUM_IRQ + 31) / 32;
   localparam int NPAD  = NGRP * 32;
   localparam int NPW   = (NUM_IRQ + 3) / 4;
   localparam int NPB   = NPW * 32;
   localparam int DEPTH = (NUM_IRQ < (1 << PRIO_BITS)) ? NUM_IRQ : (1 << PRIO_BITS);

   if (NUM_IRQ < 1 || NUM_IRQ > 240) begin : g_bad_num
      $error("NUM_IRQ must lie in 1..240");
   end
   if (PRIO_BITS < 3 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must lie in 3..8");
   end

   logic [NUM_IRQ-1:0]   en_q, pd_q, act_q, line_q;
   logic [NUM_IRQ*8-1:0] pb;
   logic [2:0]           split_q;
   logic                 acc_fire, ret_fire, stk_empty, stk_full;
   logic [7:0]           stk_top;

   assign acc_fire = core_accept && core_req;
   assign ret_fire = core_return && !stk_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) split_q <= 3'd0;
      else if (bus_we && bus_addr == A_SPLIT) split_q <= bus_wdata[2:0];
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      localparam int G = i / 32;
      localparam int B = i % 32;
      localparam int K = i / 4;
      localparam int L = i % 4;
      logic [PRIO_BITS-1:0] prio_q;
      logic se, ce, sp, cp, trg, edg, acc, ret;

      assign se  = bus_we && bus_addr == 7'(A_SETEN + G) && bus_wdata[B];
      assign ce  = bus_we && bus_addr == 7'(A_CLREN + G) && bus_wdata[B];
      assign sp  = bus_we && bus_addr == 7'(A_SETPD + G) && bus_wdata[B];
      assign cp  = bus_we && bus_addr == 7'(A_CLRPD + G) && bus_wdata[B];
      assign trg = bus_we && bus_addr == A_TRIG && bus_wdata[7:0] == 8'(i);
      assign edg = irq_lines[i] && !line_q[i];
      assign acc = acc_fire && core_num == 8'(i);
      assign ret = ret_fire && stk_top == 8'(i);
      assign pb[i*8 +: 8] = 8'({prio_q, 8'h00} >> PRIO_BITS);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[i]   <= 1'b0;
            pd_q[i]   <= 1'b0;
            act_q[i]  <= 1'b0;
            line_q[i] <= 1'b0;
            prio_q    <= '0;
         end else begin
            line_q[i] <= irq_lines[i];
            en_q[i]   <= (en_q[i] && !ce) || se;
            pd_q[i]   <= (pd_q[i] && !cp && !acc) || sp || trg || edg;
            act_q[i]  <= (act_q[i] && !ret) || acc;
            if (bus_we && bus_addr == 7'(A_PRIO + K))
               prio_q <= bus_wdata[8*L+7 -: PRIO_BITS];
         end
      end
   end

   nvic_arbiter #(.NUM_IRQ(NUM_IRQ)) i_arb (
      .cand       (en_q & pd_q & ~act_q),
      .active     (act_q),
      .prio_bytes (pb),
      .split      (split_q),
      .req        (core_req),
      .req_num    (core_num)
   );

   nvic_nest_stack #(.DEPTH(DEPTH), .W(8)) i_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (acc_fire),
      .pop       (ret_fire),
      .push_data (core_num),
      .top       (stk_top),
      .empty     (stk_empty),
      .full      (stk_full)
   );

   logic [NPAD-1:0] en_pad, pd_pad, act_pad;
   logic [NPB-1:0]  pb_pad;
   assign en_pad  = NPAD'(en_q);
   assign pd_pad  = NPAD'(pd_q);
   assign act_pad = NPAD'(act_q);
   assign pb_pad  = NPB'(pb);

   always_comb begin
      bus_rdata = 32'd0;
      if (bus_addr == A_TYPE)  bus_rdata[3:0] = 4'(NGRP - 1);
      if (bus_addr == A_SPLIT) bus_rdata[2:0] = split_q;
      for (int g = 0; g < NGRP; g++) begin
         if (bus_addr == 7'(A_SETEN + g) || bus_addr == 7'(A_CLREN + g))
            bus_rdata = en_pad[g*32 +: 32];
         if (bus_addr == 7'(A_SETPD + g) || bus_addr == 7'(A_CLRPD + g))
            bus_rdata = pd_pad[g*32 +: 32];
         if (bus_addr == 7'(A_ACT + g))
            bus_rdata = act_pad[g*32 +: 32];
      end
      for (int k = 0; k < NPW; k++) begin
         if (bus_addr == 7'(A_PRIO + k)) bus_rdata = pb_pad[k*32 +: 32];
      end
   end

   // wide copies so an 8-bit number indexes them exactly
   logic [255:0] en_w, pd_w, act_w;
   assign en_w  = 256'(en_q);
   assign pd_w  = 256'(pd_q);
   assign act_w = 256'(act_q);

   // R4
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> en_w[core_num]);
   // R8
   req_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> (pd_w[core_num] && !act_w[core_num]));
   // R9
   accept_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_accept && core_req && !core_return) |=> act_w[$past(core_num)]);
   // R11
   return_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_return && !stk_empty && !core_accept) |=> !act_w[$past(stk_top)]);
endmodule

// File: tb/test_nvic_core.sv
module test_nvic_core;
   localparam int CLK_PERIOD = 10;
   localparam int N = 40;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] irq_lines = '0;
   logic         bus_we = 1'b0;
   logic [6:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic         core_req;
   logic [7:0]   core_num;
   logic         core_accept = 1'b0;
   logic         core_return = 1'b0;
   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvic_core #(.NUM_IRQ(N), .PRIO_BITS(3)) i_nvic_core (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .core_req(core_req), .core_num(core_num),
      .core_accept(core_accept), .core_return(core_return));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic req_chk(input string tag, input logic r, input logic [7:0] n);
      #1;
      chk({tag, " req"}, {31'd0, core_req}, {31'd0, r});
      if (r) chk({tag, " num"}, {24'd0, core_num}, {24'd0, n});
   endtask

   task automatic pulse_accept();
      @(negedge clk); core_accept = 1'b1;
      @(negedge clk); core_accept = 1'b0;
   endtask

   task automatic pulse_return();
      @(negedge clk); core_return = 1'b1;
      @(negedge clk); core_return = 1'b0;
   endtask

   task automatic clean();
      wr(7'h10, '1); wr(7'h11, '1); wr(7'h20, '1); wr(7'h21, '1); wr(7'h01, 0);
   endtask

   task automatic t_reset();
      rd_chk("R2 type", 7'h00, 32'h1);
      rd_chk("R1 split", 7'h01, 0);
      rd_chk("R1 enable", 7'h08, 0);
      rd_chk("R1 pending", 7'h18, 0);
      rd_chk("R1 active", 7'h28, 0);
      rd_chk("R1 prio", 7'h40, 0);
      req_chk("R1", 1'b0, 0);
      wr(7'h00, 32'hFFFF_FFFF);
      rd_chk("R2 type write ignored", 7'h00, 32'h1);
   endtask

   task automatic t_enable();
      wr(7'h08, 32'h0000_00F0);
      rd_chk("R3 set-enable read", 7'h08, 32'hF0);
      rd_chk("R3 clear-enable read", 7'h10, 32'hF0);
      wr(7'h10, 32'h0000_0030);
      rd_chk("R3 after clear", 7'h08, 32'hC0);
      wr(7'h09, 32'hFFFF_FFFF);
      rd_chk("R12 upper group", 7'h09, 32'hFF);
      rd_chk("R12 missing group", 7'h0A, 0);
      clean();
   endtask

   task automatic t_prio();
      wr(7'h40, 32'hFFFF_FFFF);
      rd_chk("R7 low bits zero", 7'h40, 32'hE0E0_E0E0);
      wr(7'h4A, 32'hFFFF_FFFF);
      rd_chk("R12 missing prio word", 7'h4A, 0);
      wr(7'h40, 0);
   endtask

   task automatic t_pending();
      @(negedge clk); irq_lines[5] = 1'b1;
      @(negedge clk); irq_lines[5] = 1'b0;
      rd_chk("R4 edge sets pending while disabled", 7'h18, 32'h20);
      req_chk("R4 disabled not requested", 1'b0, 0);
      wr(7'h20, 32'h20);
      rd_chk("R5 clear-pending", 7'h20, 0);
      wr(7'h19, 32'h8);
      rd_chk("R5 set-pending upper", 7'h21, 32'h8);
      wr(7'h19, 32'hFFFF_FF00);
      rd_chk("R12 pending above range", 7'h19, 32'h8);
      clean();
   endtask

   task automatic t_trigger();
      wr(7'h02, 32'd7);
      rd_chk("R6 trigger sets pending", 7'h18, 32'h80);
      wr(7'h02, 32'd45);
      rd_chk("R6 out-of-range ignored", 7'h19, 0);
      rd_chk("R6 trigger reads zero", 7'h02, 0);
      clean();
   endtask

   task automatic t_select();
      wr(7'h40, 32'h4000_0000);   // irq3 prio 2
      wr(7'h42, 32'h0000_4000);   // irq9 prio 2
      wr(7'h43, 32'h0000_0020);   // irq12 prio 1
      wr(7'h08, (1 << 3) | (1 << 9) | (1 << 12));
      wr(7'h18, (1 << 3) | (1 << 9));
      req_chk("R8 tie lower number", 1'b1, 8'd3);
      wr(7'h18, 1 << 12);
      req_chk("R8 lower value wins", 1'b1, 8'd12);
      clean();
   endtask

   task automatic t_nest();
      wr(7'h43, 32'h0000_0060);   // irq12 prio 3
      wr(7'h45, 32'h0000_0020);   // irq20 prio 1
      wr(7'h48, 32'h0000_6000);   // irq33 prio 3
      wr(7'h08, (1 << 12) | (1 << 20));
      wr(7'h09, 32'h2);
      wr(7'h18, 1 << 12);
      req_chk("R8 single", 1'b1, 8'd12);
      pulse_accept();
      rd_chk("R9 active set", 7'h28, 1 << 12);
      rd_chk("R9 pending cleared", 7'h18, 0);
      req_chk("R9 none left", 1'b0, 0);
      wr(7'h19, 32'h2);
      req_chk("R10 same group blocked", 1'b0, 0);
      wr(7'h18, 1 << 20);
      req_chk("R10 lower group preempts", 1'b1, 8'd20);
      pulse_accept();
      rd_chk("R9 nested active", 7'h28, (1 << 12) | (1 << 20));
      req_chk("R10 blocked under nest", 1'b0, 0);
      pulse_return();
      rd_chk("R11 pops latest", 7'h28, 1 << 12);
      req_chk("R11 still blocked", 1'b0, 0);
      pulse_return();
      rd_chk("R11 pops outer", 7'h28, 0);
      req_chk("R11 threshold recomputed", 1'b1, 8'd33);
      pulse_accept();
      rd_chk("R9 upper group active", 7'h29, 32'h2);
      pulse_return();
      rd_chk("R11 upper group cleared", 7'h29, 0);
      clean();
   endtask

   task automatic t_group();
      wr(7'h40, 32'h0020_6000);   // irq1 prio 3, irq2 prio 1
      wr(7'h08, 32'h6);
      wr(7'h01, 32'd6);
      rd_chk("R10 split readback", 7'h01, 32'd6);
      wr(7'h18, 32'h2);
      req_chk("R8 irq1 offered", 1'b1, 8'd1);
      pulse_accept();
      wr(7'h18, 32'h4);
      req_chk("R10 sub-priority does not preempt", 1'b0, 0);
      wr(7'h01, 32'd5);
      req_chk("R10 narrower split preempts", 1'b1, 8'd2);
      pulse_accept();
      pulse_return();
      rd_chk("R11 inner popped", 7'h28, 32'h2);
      pulse_return();
      rd_chk("R11 all clear", 7'h28, 0);
      clean();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_prio();
      t_pending();
      t_trigger();
      t_select();
      t_nest();
      t_group();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule